// File: doc/BRIEF.md
# Two-Channel Synchronous Bitstream Link Master

This block is the master end of a point-to-point synchronous bit-serial link that is used in place of a cell interface when the payload is a plain bitstream. It forwards its own clock to the far end as the common link clock. It carries two independent channels, a low-latency fast channel and an interleaved channel, on two separate sub-interfaces. Each sub-interface has a 2-bit data lane, a valid strobe and a frame marker in each direction.

On the transmit side, each channel takes bytes through a valid/ready handshake. It splits every byte into four bit pairs and releases them on its lane under a pacing rule that keeps valid strobes a fixed minimum number of cycles apart. The fast channel marks its frames from a superframe tick. The interleaved channel marks its frames from its own frame tick. On the receive side, each channel collects valid bit pairs into bytes. It aligns to the far end's frame marker and tags the byte that begins a frame.

Each transmit lane is a two-state machine. `TX_EMPTY` moves to `TX_LOADED` when a byte is accepted. `TX_LOADED` returns to `TX_EMPTY` once the last pair has been strobed. Each receive lane is also a two-state machine. `RX_HUNT` moves to `RX_ASSEM` on the first frame-marked pair. `RX_ASSEM` stays put and restarts its byte whenever a frame-marked pair arrives.

Top module: `slk_bitstream_master`

## Requirements
- R1: After reset, every transmit valid and frame marker is low, both byte inputs are ready, and both receive byte outputs are idle.
- R2: `lnk_clk` is the block clock, passed through unchanged.
- R3: On each transmit lane, two valid strobes are never closer than 8 cycles (GAP_CYC). The four pairs of one byte are strobed exactly 8 cycles apart.
- R4: A byte is sent as four valid transfers with the most significant pair first: bits [7:6], then [5:4], then [3:2], then [1:0].
- R5: A channel's frame tick arms a frame mark. The first byte loaded after the tick carries the frame marker high on its first pair only. The marker is low on every other transfer. This holds even when the tick arrives while an earlier byte is still being sent.
- R6: While a channel has no byte loaded, its valid strobe stays low. A new byte's first pair goes out as soon as the pacing gap allows.
- R7: Channel 0 (fast) takes its frame marks only from `sf_tick`. Channel 1 (interleaved) takes its frame marks only from `ilv_frm_tick`.
- R8: Receive assembly places four valid pairs into a byte, most significant pair first. The byte is shown with a one-cycle `*_out_valid` pulse in the cycle after its fourth pair is sampled. `*_out_sof` is high when the byte began with a frame-marked pair.
- R9: After reset, receive pairs are ignored until the first frame-marked pair arrives. No byte is produced from them.
- R10: A frame-marked pair that arrives in the middle of a byte drops the partial byte and starts a new one with that pair.
- R11: A byte is taken on a cycle with valid and ready both high. Ready stays low while a byte is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_clk | output | 1 | Common link clock driven to the far end |
| sf_tick | input | 1 | Superframe tick, frame timing for the fast channel |
| ilv_frm_tick | input | 1 | Frame tick for the interleaved channel |
| fst_in_data | input | 8 | Fast-channel byte to send |
| fst_in_valid | input | 1 | Fast-channel byte offered |
| fst_in_ready | output | 1 | Fast-channel byte can be taken |
| ilv_in_data | input | 8 | Interleaved-channel byte to send |
| ilv_in_valid | input | 1 | Interleaved-channel byte offered |
| ilv_in_ready | output | 1 | Interleaved-channel byte can be taken |
| tx_fst_d | output | 2 | Fast transmit bit pair |
| tx_fst_vld | output | 1 | Fast transmit valid strobe |
| tx_fst_frm | output | 1 | Fast transmit frame marker |
| tx_ilv_d | output | 2 | Interleaved transmit bit pair |
| tx_ilv_vld | output | 1 | Interleaved transmit valid strobe |
| tx_ilv_frm | output | 1 | Interleaved transmit frame marker |
| rx_fst_d | input | 2 | Fast receive bit pair |
| rx_fst_vld | input | 1 | Fast receive valid |
| rx_fst_frm | input | 1 | Fast receive frame marker |
| rx_ilv_d | input | 2 | Interleaved receive bit pair |
| rx_ilv_vld | input | 1 | Interleaved receive valid |
| rx_ilv_frm | input | 1 | Interleaved receive frame marker |
| fst_out_data | output | 8 | Fast received byte |
| fst_out_valid | output | 1 | Fast received byte pulse |
| fst_out_sof | output | 1 | Fast received byte starts a frame |
| ilv_out_data | output | 8 | Interleaved received byte |
| ilv_out_valid | output | 1 | Interleaved received byte pulse |
| ilv_out_sof | output | 1 | Interleaved received byte starts a frame |

## Verification
The bench targets four situations:
- **Pacing across byte boundaries and idle periods.** A design that reset its gap on a byte load, or strobed while empty, would show spacing under 8 cycles or a strobe the scoreboard never queued.
- **A frame tick that lands while an earlier byte is still going out.** A design that marked the byte in flight, or lost the tick, would put the marker on the wrong pair. The bench also crosses the two ticks between channels to catch a swapped frame source.
- **Receive pairs before any frame marker.** A design that skipped the hunt would emit bytes the scoreboard never expected.
- **A frame marker that cuts a byte short.** A design that kept the partial pairs would deliver misaligned bytes and a wrong start-of-frame flag.

// File: rtl/slk_pkg.sv
package slk_pkg;
    // Transmit lane: holding no byte, or holding one whose pairs are being paced out
    typedef enum logic {
        TX_EMPTY  = 1'b0,
        TX_LOADED = 1'b1
    } tx_state_t;

    // Receive lane: waiting for first frame marker, or collecting pairs into bytes
    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_ASSEM = 1'b1
    } rx_state_t;
endpackage

// File: rtl/slk_tx_lane.sv
module slk_tx_lane
    import slk_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PAIR_W  = 2,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic              frm_tick,
    output logic [PAIR_W-1:0] lane_d,
    output logic              lane_vld,
    output logic              lane_frm
);
    localparam int PAIRS  = BYTE_W / PAIR_W;
    localparam int PIDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int CNT_W  = $clog2(GAP_CYC) + 1;

    tx_state_t         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q, shreg_d;
    logic [PIDX_W-1:0] pidx_q, pidx_d;
    logic              first_q, first_d;
    logic              pend_q, pend_d;
    logic [CNT_W-1:0]  gcnt_q, gcnt_d;
    logic [PAIR_W-1:0] d_q, d_d;
    logic              vld_q, vld_d;
    logic              frm_q, frm_d;
    logic              slot_due;

    assign slot_due  = (gcnt_q == CNT_W'(GAP_CYC - 1));
    assign src_ready = (state_q == TX_EMPTY);
    assign lane_d    = d_q;
    assign lane_vld  = vld_q;
    assign lane_frm  = frm_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
            shreg_q <= '0;
            pidx_q  <= '0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
            gcnt_q  <= CNT_W'(GAP_CYC - 1);
            d_q     <= '0;
            vld_q   <= 1'b0;
            frm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            pidx_q  <= pidx_d;
            first_q <= first_d;
            pend_q  <= pend_d;
            gcnt_q  <= gcnt_d;
            d_q     <= d_d;
            vld_q   <= vld_d;
            frm_q   <= frm_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        pidx_d  = pidx_q;
        first_d = first_q;
        pend_d  = pend_q | frm_tick;
        d_d     = d_q;
        vld_d   = 1'b0;
        frm_d   = 1'b0;
        gcnt_d  = slot_due ? gcnt_q : gcnt_q + CNT_W'(1);
        unique case (state_q)
            TX_EMPTY: begin
                if (src_valid) begin
                    state_d = TX_LOADED;
                    shreg_d = src_data;
                    pidx_d  = '0;
                    first_d = pend_q | frm_tick;
                    pend_d  = 1'b0;
                end
            end
            TX_LOADED: begin
                if (slot_due) begin
                    vld_d   = 1'b1;
                    d_d     = shreg_q[BYTE_W-1 -: PAIR_W];
                    frm_d   = first_q && (pidx_q == '0);
                    shreg_d = shreg_q << PAIR_W;
                    pidx_d  = pidx_q + PIDX_W'(1);
                    gcnt_d  = '0;
                    if (pidx_q == PIDX_W'(PAIRS - 1)) begin
                        state_d = TX_EMPTY;
                        first_d = 1'b0;
                    end
                end
            end
            default: state_d = TX_EMPTY;
        endcase
    end

    // independent spacing monitor for the assertions
    logic [CNT_W-1:0] chk_since;
    logic             chk_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_since <= '0;
            chk_seen  <= 1'b0;
        end else if (vld_q) begin
            chk_since <= CNT_W'(1);
            chk_seen  <= 1'b1;
        end else if (chk_since < CNT_W'(GAP_CYC)) begin
            chk_since <= chk_since + CNT_W'(1);
        end
    end

    a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && chk_seen) |-> (chk_since >= CNT_W'(GAP_CYC)));
    a_r5_frm_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q |-> vld_q);
    a_r6_no_strobe_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_EMPTY) |=> !vld_q);
    a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_LOADED && !slot_due) |=> $stable(shreg_q));
endmodule

// File: rtl/slk_rx_lane.sv
module slk_rx_lane
    import slk_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PAIR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] lane_d,
    input  logic              lane_vld,
    input  logic              lane_frm,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sof
);
    localparam int PAIRS  = BYTE_W / PAIR_W;
    localparam int PIDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    rx_state_t         state_q, state_d;
    logic [BYTE_W-1:0] acc_q, acc_d;
    logic [PIDX_W-1:0] cnt_q, cnt_d;
    logic              first_q, first_d;
    logic [BYTE_W-1:0] od_q, od_d;
    logic              ov_q, ov_d;
    logic              os_q, os_d;
    logic [BYTE_W-1:0] shifted;

    assign shifted   = {acc_q[BYTE_W-PAIR_W-1:0], lane_d};
    assign out_data  = od_q;
    assign out_valid = ov_q;
    assign out_sof   = os_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            acc_q   <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
            od_q    <= '0;
            ov_q    <= 1'b0;
            os_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            cnt_q   <= cnt_d;
            first_q <= first_d;
            od_q    <= od_d;
            ov_q    <= ov_d;
            os_q    <= os_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        cnt_d   = cnt_q;
        first_d = first_q;
        od_d    = od_q;
        ov_d    = 1'b0;
        os_d    = os_q;
        unique case (state_q)
            RX_HUNT: begin
                if (lane_vld && lane_frm) begin
                    state_d = RX_ASSEM;
                    acc_d   = {{(BYTE_W-PAIR_W){1'b0}}, lane_d};
                    cnt_d   = PIDX_W'(1);
                    first_d = 1'b1;
                end
            end
            RX_ASSEM: begin
                if (lane_vld && lane_frm) begin
                    acc_d   = {{(BYTE_W-PAIR_W){1'b0}}, lane_d};
                    cnt_d   = PIDX_W'(1);
                    first_d = 1'b1;
                end else if (lane_vld) begin
                    acc_d = shifted;
                    if (cnt_q == PIDX_W'(PAIRS - 1)) begin
                        ov_d    = 1'b1;
                        od_d    = shifted;
                        os_d    = first_q;
                        first_d = 1'b0;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + PIDX_W'(1);
                    end
                end
            end
            default: state_d = RX_HUNT;
        endcase
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q |=> !ov_q);
    a_r9_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HUNT && !(lane_vld && lane_frm)) |=> !ov_q);
    a_r10_restart_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld && lane_frm) |=> !ov_q);
endmodule

// File: rtl/slk_bitstream_master.sv
module slk_bitstream_master #(
    parameter int BYTE_W  = 8,
    parameter int PAIR_W  = 2,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              lnk_clk,
    input  logic              sf_tick,
    input  logic              ilv_frm_tick,
    input  logic [BYTE_W-1:0] fst_in_data,
    input  logic              fst_in_valid,
    output logic              fst_in_ready,
    input  logic [BYTE_W-1:0] ilv_in_data,
    input  logic              ilv_in_valid,
    output logic              ilv_in_ready,
    output logic [PAIR_W-1:0] tx_fst_d,
    output logic              tx_fst_vld,
    output logic              tx_fst_frm,
    output logic [PAIR_W-1:0] tx_ilv_d,
    output logic              tx_ilv_vld,
    output logic              tx_ilv_frm,
    input  logic [PAIR_W-1:0] rx_fst_d,
    input  logic              rx_fst_vld,
    input  logic              rx_fst_frm,
    input  logic [PAIR_W-1:0] rx_ilv_d,
    input  logic              rx_ilv_vld,
    input  logic              rx_ilv_frm,
    output logic [BYTE_W-1:0] fst_out_data,
    output logic              fst_out_valid,
    output logic              fst_out_sof,
    output logic [BYTE_W-1:0] ilv_out_data,
    output logic              ilv_out_valid,
    output logic              ilv_out_sof
);
    localparam int NCH = 2;  // index 0 fast, index 1 interleaved

    logic [NCH-1:0][BYTE_W-1:0] in_data, out_data;
    logic [NCH-1:0][PAIR_W-1:0] txd, rxd;
    logic [NCH-1:0]             in_valid, in_ready, ch_tick;
    logic [NCH-1:0]             txv, txf, rxv, rxf, out_valid, out_sof;

    assign lnk_clk  = clk;
    assign ch_tick  = {ilv_frm_tick, sf_tick};
    assign in_data  = {ilv_in_data, fst_in_data};
    assign in_valid = {ilv_in_valid, fst_in_valid};
    assign rxd      = {rx_ilv_d, rx_fst_d};
    assign rxv      = {rx_ilv_vld, rx_fst_vld};
    assign rxf      = {rx_ilv_frm, rx_fst_frm};

    assign fst_in_ready  = in_ready[0];
    assign ilv_in_ready  = in_ready[1];
    assign tx_fst_d      = txd[0];
    assign tx_fst_vld    = txv[0];
    assign tx_fst_frm    = txf[0];
    assign tx_ilv_d      = txd[1];
    assign tx_ilv_vld    = txv[1];
    assign tx_ilv_frm    = txf[1];
    assign fst_out_data  = out_data[0];
    assign fst_out_valid = out_valid[0];
    assign fst_out_sof   = out_sof[0];
    assign ilv_out_data  = out_data[1];
    assign ilv_out_valid = out_valid[1];
    assign ilv_out_sof   = out_sof[1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        slk_tx_lane #(
            .BYTE_W (BYTE_W),
            .PAIR_W (PAIR_W),
            .GAP_CYC(GAP_CYC)
        ) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_data (in_data[c]),
            .src_valid(in_valid[c]),
            .src_ready(in_ready[c]),
            .frm_tick (ch_tick[c]),
            .lane_d   (txd[c]),
            .lane_vld (txv[c]),
            .lane_frm (txf[c])
        );
        slk_rx_lane #(
            .BYTE_W(BYTE_W),
            .PAIR_W(PAIR_W)
        ) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .lane_d   (rxd[c]),
            .lane_vld (rxv[c]),
            .lane_frm (rxf[c]),
            .out_data (out_data[c]),
            .out_valid(out_valid[c]),
            .out_sof  (out_sof[c])
        );
    end
endmodule

// File: tb/slk_bitstream_master_bench.sv
`timescale 1ns/1ps
module slk_bitstream_master_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic       lnk_clk, sf_tick = 0, ilv_frm_tick = 0;
    logic [7:0] fst_in_data = 0, ilv_in_data = 0;
    logic       fst_in_valid = 0, ilv_in_valid = 0, fst_in_ready, ilv_in_ready;
    logic [1:0] tx_fst_d, tx_ilv_d;
    logic       tx_fst_vld, tx_fst_frm, tx_ilv_vld, tx_ilv_frm;
    logic [1:0] rx_fst_d = 0, rx_ilv_d = 0;
    logic       rx_fst_vld = 0, rx_fst_frm = 0, rx_ilv_vld = 0, rx_ilv_frm = 0;
    logic [7:0] fst_out_data, ilv_out_data;
    logic       fst_out_valid, fst_out_sof, ilv_out_valid, ilv_out_sof;

    slk_bitstream_master u_slk_bitstream_master (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk),
        .sf_tick(sf_tick), .ilv_frm_tick(ilv_frm_tick),
        .fst_in_data(fst_in_data), .fst_in_valid(fst_in_valid), .fst_in_ready(fst_in_ready),
        .ilv_in_data(ilv_in_data), .ilv_in_valid(ilv_in_valid), .ilv_in_ready(ilv_in_ready),
        .tx_fst_d(tx_fst_d), .tx_fst_vld(tx_fst_vld), .tx_fst_frm(tx_fst_frm),
        .tx_ilv_d(tx_ilv_d), .tx_ilv_vld(tx_ilv_vld), .tx_ilv_frm(tx_ilv_frm),
        .rx_fst_d(rx_fst_d), .rx_fst_vld(rx_fst_vld), .rx_fst_frm(rx_fst_frm),
        .rx_ilv_d(rx_ilv_d), .rx_ilv_vld(rx_ilv_vld), .rx_ilv_frm(rx_ilv_frm),
        .fst_out_data(fst_out_data), .fst_out_valid(fst_out_valid), .fst_out_sof(fst_out_sof),
        .ilv_out_data(ilv_out_data), .ilv_out_valid(ilv_out_valid), .ilv_out_sof(ilv_out_sof)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    logic [2:0] q_tx0[$], q_tx1[$];   // {frm, pair}
    logic [8:0] q_rx0[$], q_rx1[$];   // {sof, byte}
    bit pend[2];
    int last_t[2], k_t[2];
    bit seen_t[2];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- transmit driver ----------------
    task automatic send_tx(input int ch, input logic [7:0] b, input bit tick);
        logic [2:0] item;
        bit f;
        if (tick) begin
            @(negedge clk);
            if (ch == 0) sf_tick = 1; else ilv_frm_tick = 1;
            @(negedge clk);
            if (ch == 0) sf_tick = 0; else ilv_frm_tick = 0;
            pend[ch] = 1;
        end
        f = pend[ch];
        pend[ch] = 0;
        for (int i = 0; i < 4; i++) begin
            item = {f && (i == 0), b[7-2*i -: 2]};
            if (ch == 0) q_tx0.push_back(item); else q_tx1.push_back(item);
        end
        forever begin
            @(negedge clk);
            if ((ch == 0) ? fst_in_ready : ilv_in_ready) break;
        end
        if (ch == 0) begin fst_in_data = b; fst_in_valid = 1; end
        else         begin ilv_in_data = b; ilv_in_valid = 1; end
        @(negedge clk);
        if (ch == 0) fst_in_valid = 0; else ilv_in_valid = 0;
        // R11: ready drops while the byte is held
        chk(((ch == 0) ? fst_in_ready : ilv_in_ready) == 1'b0, "R11 ready while loaded", 1, 0);
    endtask

    // ---------------- transmit monitor ----------------
    task automatic mon_tx(input int ch, input logic v, input logic f, input logic [1:0] d);
        logic [2:0] e;
        if (!v) begin
            if (f) chk(0, "R5 marker without valid", 1, 0);
            return;
        end
        if (seen_t[ch]) begin
            chk(cyc - last_t[ch] >= 8, "R3 min gap", cyc - last_t[ch], 8);
            if (k_t[ch] != 0) chk(cyc - last_t[ch] == 8, "R3 in-byte spacing", cyc - last_t[ch], 8);
        end
        seen_t[ch] = 1;
        last_t[ch] = cyc;
        k_t[ch] = (k_t[ch] + 1) % 4;
        if ((ch == 0) ? (q_tx0.size() == 0) : (q_tx1.size() == 0)) begin
            chk(0, "R6 strobe with nothing queued", {f, d}, 0);
        end else begin
            e = (ch == 0) ? q_tx0.pop_front() : q_tx1.pop_front();
            chk({f, d} == e, (ch == 0) ? "R4 R5 R7 fast pair" : "R4 R5 R7 ilv pair", {f, d}, e);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        mon_tx(0, tx_fst_vld, tx_fst_frm, tx_fst_d);
        mon_tx(1, tx_ilv_vld, tx_ilv_frm, tx_ilv_d);
    end

    // ---------------- receive driver ----------------
    task automatic rx_pair(input int ch, input logic [1:0] d, input logic f);
        @(negedge clk);
        if (ch == 0) begin rx_fst_d = d; rx_fst_vld = 1; rx_fst_frm = f; end
        else         begin rx_ilv_d = d; rx_ilv_vld = 1; rx_ilv_frm = f; end
        @(negedge clk);
        if (ch == 0) begin rx_fst_vld = 0; rx_fst_frm = 0; end
        else         begin rx_ilv_vld = 0; rx_ilv_frm = 0; end
    endtask

    task automatic rx_byte(input int ch, input logic [7:0] b, input bit f, input bit expect_out);
        if (expect_out) begin
            if (ch == 0) q_rx0.push_back({f, b}); else q_rx1.push_back({f, b});
        end
        for (int i = 0; i < 4; i++) rx_pair(ch, b[7-2*i -: 2], f && (i == 0));
    endtask

    // ---------------- receive monitor ----------------
    task automatic mon_rx(input int ch, input logic v, input logic s, input logic [7:0] d);
        logic [8:0] e;
        if (!v) return;
        if ((ch == 0) ? (q_rx0.size() == 0) : (q_rx1.size() == 0)) begin
            chk(0, "R9 R10 unexpected byte", {s, d}, 0);
        end else begin
            e = (ch == 0) ? q_rx0.pop_front() : q_rx1.pop_front();
            chk({s, d} == e, "R8 received byte", {s, d}, e);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        mon_rx(0, fst_out_valid, fst_out_sof, fst_out_data);
        mon_rx(1, ilv_out_valid, ilv_out_sof, ilv_out_data);
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(tx_fst_vld == 0 && tx_ilv_vld == 0, "R1 tx valid idle", {tx_fst_vld, tx_ilv_vld}, 0);
        chk(tx_fst_frm == 0 && tx_ilv_frm == 0, "R1 tx marker idle", {tx_fst_frm, tx_ilv_frm}, 0);
        chk(fst_in_ready == 1 && ilv_in_ready == 1, "R1 ready", {fst_in_ready, ilv_in_ready}, 3);
        chk(fst_out_valid == 0 && ilv_out_valid == 0, "R1 rx idle", {fst_out_valid, ilv_out_valid}, 0);
        // R2 clock pass-through
        chk(lnk_clk == 1'b0, "R2 link clock low phase", lnk_clk, 0);
        @(posedge clk); #1;
        chk(lnk_clk == 1'b1, "R2 link clock high phase", lnk_clk, 1);

        fork
            begin
                send_tx(0, 8'hB4, 1);
                send_tx(0, 8'h1E, 0);
                repeat (60) @(negedge clk);   // R6 idle: no strobes allowed
                send_tx(0, 8'hC3, 0);
                send_tx(0, 8'h5A, 1);          // tick while previous byte in flight
                send_tx(0, 8'hFF, 0);
                send_tx(0, 8'h00, 1);
            end
            begin
                repeat (5) @(negedge clk);
                send_tx(1, 8'h69, 0);
                send_tx(1, 8'h96, 1);
                repeat (23) @(negedge clk);
                send_tx(1, 8'h0F, 0);
                send_tx(1, 8'hA5, 1);
            end
            begin
                rx_byte(0, 8'h3C, 0, 0);       // R9 before alignment
                rx_byte(0, 8'hE7, 1, 1);
                rx_byte(0, 8'h81, 0, 1);
                rx_pair(0, 2'b11, 0);          // R10 partial byte
                rx_pair(0, 2'b01, 0);
                rx_byte(0, 8'h42, 1, 1);
                rx_byte(0, 8'hDB, 0, 1);
            end
            begin
                rx_byte(1, 8'h55, 1, 1);
                rx_pair(1, 2'b10, 0);          // R10 partial
                rx_byte(1, 8'hC6, 1, 1);
                rx_byte(1, 8'h1B, 0, 1);
            end
        join
        repeat (100) @(negedge clk);
        chk(q_tx0.size() == 0, "R6 fast pairs all sent", q_tx0.size(), 0);
        chk(q_tx1.size() == 0, "R6 ilv pairs all sent", q_tx1.size(), 0);
        chk(q_rx0.size() == 0, "R8 fast bytes all received", q_rx0.size(), 0);
        chk(q_rx1.size() == 0, "R8 ilv bytes all received", q_rx1.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule